// File: doc/BRIEF.md
# Cascaded Interrupt Cause Controller

This block gathers level-sensitive interrupt requests from three 32-bit source groups. The groups are a low main word, a high main word and a bank of general-purpose pin inputs. It turns them into one vector number per processor. For the first processor it masks each cause bit, discards positions that can never be real sources, and picks the lowest-numbered pending request. Low-word positions come first, then the high word, then the pins. Together the three groups cover a vector space of 0 to 95.

The pin requests reach the main search only through four summary positions in the high word. When one of these summaries wins, the controller looks into the pin cause register for the lowest pending, enabled pin. Pin cause bits are sticky: each one is cleared by writing a zero to it. The second processor sees only the doorbell request, which sits in the low word, under its own enable bit.

Software reaches the masks, the pin cause register and the two vector words through one small register port. Writes are synchronous and reads are combinational. A vector word holds a valid flag in bit 31, a spurious flag in bit 30 and the vector number in bits 6:0. Each processor also has a registered interrupt line.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: A pending, enabled, reportable low-word bit i yields vector word 0x80000000 | i and wins over any high-word or pin request.
- R2: With no low-word candidate, a pending, enabled, reportable high-word bit h outside 24..27 yields 0x80000000 | (32 + h).
- R3: Within each search stage the lowest set index wins. The stages are searched in this order: low word, high word, pin cause word.
- R4: Only low-word positions in 0x3DFFFFFE and high-word positions in 0x1F0003F7 are ever reported. Other positions never yield a vector and never raise an interrupt line.
- R5: High-word bit 24+k is the OR of pin cause bits 8k to 8k+7, and the hi_src input at bits 24..27 is ignored. When such a summary wins, the vector is 64 plus the lowest pin cause bit that is both set and enabled in the pin mask.
- R6: A pin cause bit is set while its input is high and holds after the input falls. Writing 0 to it at address 3 clears it, but only if its input is low in that cycle. Writing 1 leaves it unchanged.
- R7: If nothing qualifies, or a summary wins but no enabled pin cause bit is set, the vector word is 0x4000007F.
- R8: After reset the masks read as follows: address 0 (low mask) reads 0, address 1 (high mask) reads 0x0F000000, address 2 (pin mask) reads 0, address 4 (doorbell enable, bit 0) reads 0, and address 3 (pin cause) reads 0. Both interrupt lines are 0.
- R9: Address 6 reads 0x8000001C when low-word bit 28 is pending and the doorbell enable is set, and 0x4000007F otherwise. irq_cpu1 follows this one cycle later, and no other source affects either.
- R10: irq_cpu0 is high exactly when the previous cycle had a pending, enabled, reportable bit in the low word or the high word, summaries included.
- R11: Address 5 returns the first processor's vector word. Main-word causes follow their inputs with one register stage, so a source that falls is no longer reported one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lo_src | input | 32 | Low main-word level sources |
| hi_src | input | 32 | High main-word level sources (bits 24..27 unused) |
| pin_src | input | 32 | General-purpose pin level sources |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq_cpu0 | output | 1 | First processor interrupt line, registered |
| irq_cpu1 | output | 1 | Second processor doorbell line, registered |

## Verification
Single-bit sweeps walk one request across every position of each word with all masks open. These sweeps separate reportable positions from filtered ones and confirm the base offset of each stage, and the pin sweep also exercises the sticky hold and the zero-write clear. Sparse pseudo-random mixes of all three words under random masks are compared against an arithmetic model, which tells apart the stage order, the lowest-index rule and the masking. Directed cases cover a summary that wins with no enabled pin behind it, a write-one that leaves a cause alone, a clear that loses to an asserted input, and a doorbell that reaches only the second processor.

// File: rtl/irq_cascade_pkg.sv
// Shared constants for the cascaded interrupt cause controller.
// Assumes 32-bit cause words and a 7-bit vector space of 0..95.
package irq_cascade_pkg;
    localparam int WORD_W       = 32;
    localparam int VEC_W        = 7;
    localparam int SUM_LSB      = 24;
    localparam int SUM_NUM      = 4;
    localparam int DB_BIT       = 28;
    localparam int ADDR_W       = 3;

    localparam logic [WORD_W-1:0] LO_VALID  = 32'h3DFF_FFFE;
    localparam logic [WORD_W-1:0] HI_VALID  = 32'h1F00_03F7;
    localparam logic [WORD_W-1:0] SUM_FIELD = WORD_W'(((1 << SUM_NUM) - 1) << SUM_LSB);
    localparam logic [WORD_W-1:0] HI_MASK_RST = SUM_FIELD;

    localparam logic [WORD_W-1:0] SPURIOUS_WORD = 32'h4000_007F;

    localparam logic [ADDR_W-1:0] A_MASK_LO   = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK_HI   = 3'd1;
    localparam logic [ADDR_W-1:0] A_PIN_MASK  = 3'd2;
    localparam logic [ADDR_W-1:0] A_PIN_CAUSE = 3'd3;
    localparam logic [ADDR_W-1:0] A_DB_MASK   = 3'd4;
    localparam logic [ADDR_W-1:0] A_VEC0      = 3'd5;
    localparam logic [ADDR_W-1:0] A_VEC1      = 3'd6;

    // Build a vector word: valid flag, or the spurious code.
    function automatic logic [WORD_W-1:0] pack_vec(input logic ok, input logic [VEC_W-1:0] v);
        return ok ? {1'b1, 1'b0, {(WORD_W-2-VEC_W){1'b0}}, v} : SPURIOUS_WORD;
    endfunction
endpackage

// File: rtl/lowest_set.sv
// Finds the lowest set bit of a request vector.
// Assumes W is at least 2; idx is zero when hit is low.
module lowest_set #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set index is written last.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        hit = |req;
    end
endmodule

// File: rtl/pin_cause_bank.sv
// Sticky pin cause register with write-zero-to-clear and group summaries.
// Assumes W is a multiple of GROUPS; an asserted input beats a clear.
module pin_cause_bank #(
    parameter int W      = 32,
    parameter int GROUPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      pin_src,
    input  logic              clr_we,
    input  logic [W-1:0]      clr_data,
    output logic [W-1:0]      cause,
    output logic [GROUPS-1:0] summary
);
    localparam int GW = W / GROUPS;

    logic [W-1:0] cause_q;

    // Hold each set bit, drop it on a zero write, set it while its input is high.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & (clr_we ? clr_data : {W{1'b1}})) | pin_src;
    end

    assign cause = cause_q;

    // One summary per group of pins, unmasked.
    for (genvar g = 0; g < GROUPS; g++) begin : g_sum
        assign summary[g] = |cause_q[g*GW +: GW];
    end
endmodule

// File: rtl/vector_resolver.sv
// Combinational priority search over low word, high word, then pin cause.
// Assumes the high cause already carries the pin summaries in its field.
module vector_resolver
    import irq_cascade_pkg::*;
(
    input  logic [WORD_W-1:0] lo_cause,
    input  logic [WORD_W-1:0] hi_cause,
    input  logic [WORD_W-1:0] pin_cause,
    input  logic [WORD_W-1:0] mask_lo,
    input  logic [WORD_W-1:0] mask_hi,
    input  logic [WORD_W-1:0] pin_mask,
    input  logic              db_en,
    output logic [WORD_W-1:0] word0,
    output logic [WORD_W-1:0] word1,
    output logic              any0,
    output logic              any1
);
    localparam int IW = $clog2(WORD_W);
    localparam logic [IW-1:0] SUM_FIRST = IW'(SUM_LSB);
    localparam logic [IW-1:0] SUM_LAST  = IW'(SUM_LSB + SUM_NUM - 1);

    logic [WORD_W-1:0] lo_eff, hi_eff, pin_eff;
    logic              lo_hit, hi_hit, pin_hit;
    logic [IW-1:0]     lo_idx, hi_idx, pin_idx;
    logic              ok0;
    logic [VEC_W-1:0]  vec0;

    assign lo_eff  = lo_cause & LO_VALID & mask_lo;
    assign hi_eff  = hi_cause & HI_VALID & mask_hi;
    assign pin_eff = pin_cause & pin_mask;

    lowest_set #(.W(WORD_W)) u_lo  (.req(lo_eff),  .hit(lo_hit),  .idx(lo_idx));
    lowest_set #(.W(WORD_W)) u_hi  (.req(hi_eff),  .hit(hi_hit),  .idx(hi_idx));
    lowest_set #(.W(WORD_W)) u_pin (.req(pin_eff), .hit(pin_hit), .idx(pin_idx));

    // Stage selection: low first, then high, cascading into pins on a summary.
    always_comb begin
        ok0  = 1'b0;
        vec0 = '0;
        if (lo_hit) begin
            ok0  = 1'b1;
            vec0 = {2'b00, lo_idx};
        end else if (hi_hit) begin
            if (hi_idx >= SUM_FIRST && hi_idx <= SUM_LAST) begin
                ok0  = pin_hit;
                vec0 = {2'b10, pin_idx};
            end else begin
                ok0  = 1'b1;
                vec0 = {2'b01, hi_idx};
            end
        end
    end

    assign word0 = pack_vec(ok0, vec0);
    assign any0  = lo_hit | hi_hit;
    assign any1  = lo_cause[DB_BIT] & db_en;
    assign word1 = pack_vec(any1, VEC_W'(DB_BIT));
endmodule

// File: rtl/irq_cascade_ctrl.sv
// Top of the cascaded interrupt cause controller: cause registers, masks,
// register port and registered per-processor interrupt lines.
// Assumes level-sensitive sources already synchronous to clk.
module irq_cascade_ctrl
    import irq_cascade_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       lo_src,
    input  logic [31:0]       hi_src,
    input  logic [31:0]       pin_src,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq_cpu0,
    output logic              irq_cpu1
);
    logic [WORD_W-1:0]  lo_cause, hi_q, hi_cause;
    logic [WORD_W-1:0]  mask_lo, mask_hi, pin_mask;
    logic               db_en;
    logic [WORD_W-1:0]  pin_cause;
    logic [SUM_NUM-1:0] summary;
    logic [WORD_W-1:0]  vec0_word, vec1_word;
    logic               any0, any1;
    logic               pin_clr_we;

    // Register the main-word level sources once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cause <= '0;
            hi_q     <= '0;
        end else begin
            lo_cause <= lo_src;
            hi_q     <= hi_src;
        end
    end

    // Mask and doorbell-enable registers written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_lo  <= '0;
            mask_hi  <= HI_MASK_RST;
            pin_mask <= '0;
            db_en    <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_MASK_LO:  mask_lo  <= wr_data;
                A_MASK_HI:  mask_hi  <= wr_data;
                A_PIN_MASK: pin_mask <= wr_data;
                A_DB_MASK:  db_en    <= wr_data[0];
                default: ;
            endcase
        end
    end

    assign pin_clr_we = wr_en && (wr_addr == A_PIN_CAUSE);

    pin_cause_bank #(.W(WORD_W), .GROUPS(SUM_NUM)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_src  (pin_src),
        .clr_we   (pin_clr_we),
        .clr_data (wr_data),
        .cause    (pin_cause),
        .summary  (summary)
    );

    // Replace the high-word summary field with the pin group summaries.
    assign hi_cause = (hi_q & ~SUM_FIELD) | (WORD_W'(summary) << SUM_LSB);

    vector_resolver u_res (
        .lo_cause  (lo_cause),
        .hi_cause  (hi_cause),
        .pin_cause (pin_cause),
        .mask_lo   (mask_lo),
        .mask_hi   (mask_hi),
        .pin_mask  (pin_mask),
        .db_en     (db_en),
        .word0     (vec0_word),
        .word1     (vec1_word),
        .any0      (any0),
        .any1      (any1)
    );

    // Register the interrupt lines one cycle behind the resolver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_cpu0 <= 1'b0;
            irq_cpu1 <= 1'b0;
        end else begin
            irq_cpu0 <= any0;
            irq_cpu1 <= any1;
        end
    end

    // Read multiplexer for the register port.
    always_comb begin
        case (rd_addr)
            A_MASK_LO:   rd_data = mask_lo;
            A_MASK_HI:   rd_data = mask_hi;
            A_PIN_MASK:  rd_data = pin_mask;
            A_PIN_CAUSE: rd_data = pin_cause;
            A_DB_MASK:   rd_data = {31'b0, db_en};
            A_VEC0:      rd_data = vec0_word;
            A_VEC1:      rd_data = vec1_word;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_cascade_chk.sv
// Assertion checker for irq_cascade_ctrl, attached by bind below.
// Assumes synchronous active-low reset on rst_n.
module irq_cascade_chk
    import irq_cascade_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] lo_cause,
    input logic [31:0] pin_cause,
    input logic [31:0] pin_mask,
    input logic [31:0] pin_src,
    input logic [31:0] vec0_word,
    input logic [31:0] vec1_word,
    input logic        irq_cpu0,
    input logic        irq_cpu1
);
    a_r4_lo_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (vec0_word[31] && vec0_word[6:5] == 2'b00) |-> LO_VALID[vec0_word[4:0]]);

    a_r4_hi_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (vec0_word[31] && vec0_word[6:5] == 2'b01) |-> HI_VALID[vec0_word[4:0]]);

    a_r5_pin_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (vec0_word[31] && vec0_word[6]) |-> (pin_cause[vec0_word[4:0]] && pin_mask[vec0_word[4:0]]));

    a_r6_pin_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pin_cause & $past(pin_src)) == $past(pin_src)));

    a_r7_spurious_code: assert property (@(posedge clk) disable iff (!rst_n)
        vec0_word[30] |-> (!vec0_word[31] && vec0_word[6:0] == 7'h7F));

    a_r9_cpu1_doorbell: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cpu1 |-> $past(lo_cause[DB_BIT]));

    a_r9_cpu1_vector: assert property (@(posedge clk) disable iff (!rst_n)
        vec1_word[31] |-> (vec1_word[6:0] == 7'd28 && lo_cause[DB_BIT]));

    a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        vec0_word[31] |=> irq_cpu0);
endmodule

bind irq_cascade_ctrl irq_cascade_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lo_cause  (lo_cause),
    .pin_cause (pin_cause),
    .pin_mask  (pin_mask),
    .pin_src   (pin_src),
    .vec0_word (vec0_word),
    .vec1_word (vec1_word),
    .irq_cpu0  (irq_cpu0),
    .irq_cpu1  (irq_cpu1)
);

// File: tb/tb_irq_cascade_ctrl.sv
`timescale 1ns/1ps
module tb_irq_cascade_ctrl;
    localparam logic [31:0] LOV  = 32'h3DFF_FFFE;
    localparam logic [31:0] HIV  = 32'h1F00_03F7;
    localparam logic [31:0] SPUR = 32'h4000_007F;
    localparam logic [31:0] OK   = 32'h8000_0000;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] lo_src = 0, hi_src = 0, pin_src = 0;
    logic        wr_en = 0;
    logic [2:0]  wr_addr = 0, rd_addr = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data;
    logic        irq_cpu0, irq_cpu1;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    irq_cascade_ctrl dut (
        .clk(clk), .rst_n(rst_n), .lo_src(lo_src), .hi_src(hi_src), .pin_src(pin_src),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_cpu0(irq_cpu0), .irq_cpu1(irq_cpu1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] rnd();
        seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
        return seed;
    endfunction

    // Arithmetic expectation of the first-processor vector word.
    function automatic logic [31:0] model0(input logic [31:0] lo, hi, pc, mlo, mhi, mp);
        logic [31:0] hc, le, he, pe;
        hc = hi & ~32'h0F00_0000;
        for (int g = 0; g < 4; g++) if (|pc[g*8 +: 8]) hc[24+g] = 1'b1;
        le = lo & LOV & mlo;
        he = hc & HIV & mhi;
        pe = pc & mp;
        for (int i = 0; i < 32; i++) if (le[i]) return OK | i;
        for (int i = 0; i < 32; i++) begin
            if (he[i]) begin
                if (i >= 24 && i <= 27) begin
                    for (int j = 0; j < 32; j++) if (pe[j]) return OK | (64 + j);
                    return SPUR;
                end
                return OK | (32 + i);
            end
        end
        return SPUR;
    endfunction

    function automatic logic model_irq(input logic [31:0] lo, hi, pc, mlo, mhi);
        logic [31:0] hc;
        hc = hi & ~32'h0F00_0000;
        for (int g = 0; g < 4; g++) if (|pc[g*8 +: 8]) hc[24+g] = 1'b1;
        return |(lo & LOV & mlo) || |(hc & HIV & mhi);
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, lo, hi, pn, mlo, mhi, mp;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R8: reset state of masks, cause and lines.
        rd(3'd0, d); chk("R8 mask_lo", d, 0);
        rd(3'd1, d); chk("R8 mask_hi", d, 32'h0F00_0000);
        rd(3'd2, d); chk("R8 pin_mask", d, 0);
        rd(3'd3, d); chk("R8 pin_cause", d, 0);
        rd(3'd4, d); chk("R8 db_en", d, 0);
        chk("R8 irq0", {31'b0, irq_cpu0}, 0);
        chk("R8 irq1", {31'b0, irq_cpu1}, 0);
        rd(3'd5, d); chk("R7 idle vec0", d, SPUR);

        wr(3'd0, '1); wr(3'd1, '1); wr(3'd2, '1);

        // R1 R4 R11: walk each low-word position.
        for (int i = 0; i < 32; i++) begin
            lo_src = 32'h1 << i; settle();
            rd(3'd5, d);
            chk("R1 R4 lo walk", d, LOV[i] ? (OK | i) : SPUR);
            chk("R10 R4 lo irq", {31'b0, irq_cpu0}, {31'b0, LOV[i]});
        end
        lo_src = 0; @(negedge clk);
        rd(3'd5, d); chk("R11 level drop", d, SPUR);

        // R2 R4 R5: walk each high-word position; summary field input ignored.
        for (int i = 0; i < 32; i++) begin
            hi_src = 32'h1 << i; settle();
            rd(3'd5, d);
            chk("R2 R4 R5 hi walk", d, (HIV[i] && !(i >= 24 && i <= 27)) ? (OK | (32 + i)) : SPUR);
        end
        hi_src = 0; settle();

        // R5 R6: each pin held sticky, reported, then cleared by zero write.
        for (int j = 0; j < 32; j++) begin
            pin_src = 32'h1 << j; settle();
            pin_src = 0; settle();
            rd(3'd5, d); chk("R5 R6 pin held", d, OK | (64 + j));
            wr(3'd3, ~(32'h1 << j));
            rd(3'd3, d); chk("R6 pin cleared", d, 0);
            rd(3'd5, d); chk("R6 vec after clear", d, SPUR);
        end

        // R6: write of ones keeps; clear loses to an asserted input.
        pin_src = 32'h5; settle(); pin_src = 0;
        wr(3'd3, '1);
        rd(3'd3, d); chk("R6 write one keeps", d, 32'h5);
        pin_src = 32'h4;
        wr(3'd3, 32'h0);
        rd(3'd3, d); chk("R6 set beats clear", d, 32'h4);
        pin_src = 0; wr(3'd3, 0);
        rd(3'd3, d); chk("R6 clear all", d, 0);

        // R7: summary wins with no enabled pin pending.
        wr(3'd2, 32'h8);
        pin_src = 32'h200; settle();
        rd(3'd5, d); chk("R7 summary spurious", d, SPUR);
        chk("R7 R10 irq on summary", {31'b0, irq_cpu0}, 1);
        wr(3'd2, 32'h200);
        rd(3'd5, d); chk("R5 enabled pin", d, OK | 73);
        pin_src = 0; wr(3'd3, 0); wr(3'd2, '1);

        // R9: doorbell only reaches the second processor when enabled.
        lo_src = 32'h1000_0000; settle();
        rd(3'd6, d); chk("R9 doorbell disabled", d, SPUR);
        chk("R9 irq1 disabled", {31'b0, irq_cpu1}, 0);
        wr(3'd4, 1); wr(3'd0, 0); @(negedge clk);
        rd(3'd6, d); chk("R9 doorbell vec", d, 32'h8000_001C);
        chk("R9 irq1", {31'b0, irq_cpu1}, 1);
        rd(3'd5, d); chk("R9 cpu0 masked", d, SPUR);
        lo_src = 32'h0000_0002; hi_src = 32'h1; settle();
        rd(3'd6, d); chk("R9 other sources", d, SPUR);
        chk("R9 irq1 other", {31'b0, irq_cpu1}, 0);
        lo_src = 0; hi_src = 0;

        // R3 R10: sparse random mixes under random masks.
        for (int n = 0; n < 150; n++) begin
            pin_src = 0; @(negedge clk);
            wr(3'd3, 0);
            mlo = rnd() | rnd(); mhi = rnd() | rnd(); mp = rnd() | rnd();
            wr(3'd0, mlo); wr(3'd1, mhi); wr(3'd2, mp);
            lo = rnd() & rnd() & rnd(); hi = rnd() & rnd();
            pn = rnd() & rnd() & rnd();
            if (n % 3 == 0) lo = 0;
            if (n % 5 == 0) hi = 0;
            lo_src = lo; hi_src = hi; pin_src = pn; settle();
            rd(3'd5, d); chk("R3 random vec", d, model0(lo, hi, pn, mlo, mhi, mp));
            chk("R10 random irq", {31'b0, irq_cpu0}, {31'b0, model_irq(lo, hi, pn, mlo, mhi)});
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule